// File: doc/BRIEF.md
# Power-Up and Mute Sequencer

This block is the supervisory controller of a multi-channel analog volume stage. It takes the device from power-on through a reset hold and an automatic offset calibration into normal operation. It also handles the hardware mute pin and supply brown-out. All of its timing is counted in pulses of a millisecond tick, so every interval is a parameter in milliseconds.

Both muting and unmuting happen channel by channel. Each output is switched off, or back on, when that channel reports a zero crossing of its signal, or when a shared timeout expires, whichever comes first. Every power-up ends with a calibration followed by a one-cycle strobe that forces all gain codes to zero, which is the software-mute state. Every hardware mute also runs a calibration once all outputs are off. If a supply drops out, all outputs are cut at once and the whole power-up sequence begins again.

Top module: `pwr_mute_seq`

## Requirements
- R1: After reset, and while `supply_ok` is low, `hw_mute` is 1, `out_disc` is all ones and `cal_req` is 0. `cal_req` stays 0 until `RST_MS` ticks have been counted with the supply good.
- R2: Once the `RST_MS`-th tick of the power-up hold has been counted, `cal_req` rises with no other input needed. It stays high until `cal_done` is seen.
- R3: If `cal_done` does not arrive, calibration ends after `CAL_WD_MS` ticks and the sequence moves on.
- R4: When a power-up calibration ends, `gains_clear` pulses high for exactly one cycle. Ending a mute calibration produces no such pulse.
- R5: A low level on `mute_n` is accepted only after it has stayed low for `DEB_MS` ticks. A shorter low pulse has no effect on `hw_mute`.
- R6: While muting, a pulse on `zc_evt[i]` sets `out_disc[i]` on the next clock. Other channels are unaffected.
- R7: While muting, `ZC_MS` ticks with no crossing disconnect every channel still connected.
- R8: Once all channels are disconnected, `cal_req` is raised until `cal_done` arrives or the watchdog expires. The block then stays muted, with all outputs off, while `mute_n` is low.
- R9: When `mute_n` returns high, each channel reconnects (its `out_disc` bit goes to 0) at its own zero crossing or at the `ZC_MS` timeout. `hw_mute` falls only once every channel is connected.
- R10: Within four clocks of `supply_ok` going low, all outputs are disconnected, `hw_mute` is 1 and `cal_req` is 0. The reset hold does not count while the supply is low. The full power-up sequence restarts when the supply returns.
- R11: `cal_req` is high only while `hw_mute` is high, and while `hw_mute` is 0 every `out_disc` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| supply_ok | input | 1 | Supply comparator, 1 while both rails are above threshold (asynchronous) |
| mute_n | input | 1 | Hardware mute pin, active low (asynchronous) |
| cal_done | input | 1 | Calibration finished handshake |
| zc_evt | input | N_CH | Per-channel zero-crossing pulse |
| hw_mute | output | 1 | Hardware mute in effect |
| cal_req | output | 1 | Offset calibration request |
| gains_clear | output | 1 | One-cycle strobe forcing all gain codes to zero |
| out_disc | output | N_CH | Per-channel output disconnect, 1 = off and terminated |

## Verification
Each result has its own latency, and each check is placed to match it. A zero-crossing pulse shows on `out_disc` one clock after it is sampled. A state change, seen on `hw_mute` or `cal_req`, follows one clock after the tick that fills a timer. Pin and supply changes pass through a two-stage synchronizer, so they are seen about three clocks later. For every tick-counted interval, the bench checks once after one tick fewer than the limit, with settling clocks added, to confirm that nothing has changed yet. It then gives the final tick, allows settling clocks and checks the new state. During random zero-crossing sequences the bench stops the tick, so no timeout can interfere, and compares `out_disc` after every clock against the mask it has accumulated itself.

// File: rtl/pms_pkg.sv
package pms_pkg;
   typedef enum logic [2:0] {
      ST_POR     = 3'd0,
      ST_PCAL    = 3'd1,
      ST_RELEASE = 3'd2,
      ST_RUN     = 3'd3,
      ST_MUTING  = 3'd4,
      ST_MCAL    = 3'd5,
      ST_MUTED   = 3'd6
   } pms_state_e;
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pms_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL}};
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pms_ms_timer.sv
module pms_ms_timer #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("pms_ms_timer: LIMIT must be at least 1");
   end

   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clr)                    cnt_q <= '0;
      else if (tick && cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LIM);
endmodule

// File: rtl/pms_chan_gate.sv
module pms_chan_gate #(
   parameter int unsigned N_CH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            force_disc,
   input  logic            do_disc,
   input  logic            do_conn,
   input  logic            tmo,
   input  logic [N_CH-1:0] zc,
   output logic [N_CH-1:0] disc
);
   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic disc_q;
      logic hit;

      assign hit = zc[g] | tmo;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          disc_q <= 1'b1;
         else if (force_disc || (do_disc && hit)) disc_q <= 1'b1;
         else if (do_conn && hit)             disc_q <= 1'b0;
      end

      assign disc[g] = disc_q;
   end
endmodule

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq
   import pms_pkg::*;
#(
   parameter int unsigned N_CH      = 4,
   parameter int unsigned RST_MS    = 100,
   parameter int unsigned CAL_WD_MS = 50,
   parameter int unsigned DEB_MS    = 2,
   parameter int unsigned ZC_MS     = 16,
   parameter int unsigned SYNC_STG  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ms_tick,
   input  logic            supply_ok,
   input  logic            mute_n,
   input  logic            cal_done,
   input  logic [N_CH-1:0] zc_evt,
   output logic            hw_mute,
   output logic            cal_req,
   output logic            gains_clear,
   output logic [N_CH-1:0] out_disc
);
   if (N_CH < 1) begin : g_bad_nch
      $error("pwr_mute_seq: N_CH must be at least 1");
   end

   localparam logic [N_CH-1:0] ALL_OFF = {N_CH{1'b1}};

   logic supply_s, mute_s;
   logic mute_act, por_exp, wd_exp, zc_tmo;
   logic state_chg, in_cal, in_gate;
   pms_state_e state_q, state_d;

   pms_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_sync_sup (
      .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(supply_s));
   pms_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync_mute (
      .clk(clk), .rst_n(rst_n), .d(mute_n), .q(mute_s));

   assign state_chg = (state_d != state_q);
   assign in_cal    = (state_q == ST_PCAL) || (state_q == ST_MCAL);
   assign in_gate   = (state_q == ST_MUTING) || (state_q == ST_RELEASE);

   pms_ms_timer #(.LIMIT(DEB_MS)) u_deb (
      .clk(clk), .rst_n(rst_n), .clr(mute_s), .tick(ms_tick), .expired(mute_act));
   pms_ms_timer #(.LIMIT(RST_MS)) u_por (
      .clk(clk), .rst_n(rst_n), .clr((state_q != ST_POR) || !supply_s),
      .tick(ms_tick), .expired(por_exp));
   pms_ms_timer #(.LIMIT(CAL_WD_MS)) u_wd (
      .clk(clk), .rst_n(rst_n), .clr(!in_cal || state_chg),
      .tick(ms_tick), .expired(wd_exp));
   pms_ms_timer #(.LIMIT(ZC_MS)) u_zct (
      .clk(clk), .rst_n(rst_n), .clr(!in_gate || state_chg),
      .tick(ms_tick), .expired(zc_tmo));

   pms_chan_gate #(.N_CH(N_CH)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .force_disc(!supply_s),
      .do_disc(state_q == ST_MUTING),
      .do_conn(state_q == ST_RELEASE),
      .tmo(zc_tmo), .zc(zc_evt), .disc(out_disc));

   always_comb begin
      state_d = state_q;
      if (!supply_s) begin
         state_d = ST_POR;
      end else begin
         unique case (state_q)
            ST_POR:     if (por_exp) state_d = ST_PCAL;
            ST_PCAL:    if (cal_done || wd_exp) state_d = mute_act ? ST_MUTED : ST_RELEASE;
            ST_RELEASE: if (mute_act) state_d = ST_MUTING;
                        else if (out_disc == '0) state_d = ST_RUN;
            ST_RUN:     if (mute_act) state_d = ST_MUTING;
            ST_MUTING:  if (out_disc == ALL_OFF) state_d = ST_MCAL;
            ST_MCAL:    if (cal_done || wd_exp) state_d = ST_MUTED;
            ST_MUTED:   if (!mute_act) state_d = ST_RELEASE;
            default:    state_d = ST_POR;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_POR;
         gains_clear <= 1'b0;
      end else begin
         state_q     <= state_d;
         gains_clear <= supply_s && (state_q == ST_PCAL) && (state_d != ST_PCAL);
      end
   end

   assign cal_req = in_cal;
   assign hw_mute = (state_q != ST_RUN);
endmodule

// File: rtl/pwr_mute_seq_chk.sv
module pwr_mute_seq_chk #(
   parameter int unsigned N_CH = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            supply_s,
   input logic            hw_mute,
   input logic            cal_req,
   input logic            gains_clear,
   input logic [N_CH-1:0] out_disc
);
   // R11
   cal_in_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req |-> hw_mute);

   // R11
   live_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_mute |-> (out_disc == '0));

   // R4
   clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gains_clear |=> !gains_clear);

   // R4
   clr_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gains_clear |-> $past(cal_req));

   // R10
   supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_s |=> ((&out_disc) && hw_mute && !cal_req));
endmodule

bind pwr_mute_seq pwr_mute_seq_chk #(.N_CH(N_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .supply_s(supply_s), .hw_mute(hw_mute),
   .cal_req(cal_req), .gains_clear(gains_clear), .out_disc(out_disc));

// File: tb/pwr_mute_seq_tb.sv
module pwr_mute_seq_tb;
   localparam int CLK_P = 10;
   localparam int NCH   = 4;
   localparam int RST   = 5;
   localparam int WD    = 4;
   localparam int DEB   = 3;
   localparam int ZC    = 3;

   logic clk = 1'b0;
   logic rst_n, ms_tick, supply_ok, mute_n, cal_done;
   logic [NCH-1:0] zc_evt;
   logic hw_mute, cal_req, gains_clear;
   logic [NCH-1:0] out_disc;

   int checks = 0;
   int fails  = 0;
   int gc_cnt = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pwr_mute_seq #(.N_CH(NCH), .RST_MS(RST), .CAL_WD_MS(WD), .DEB_MS(DEB), .ZC_MS(ZC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .supply_ok(supply_ok),
      .mute_n(mute_n), .cal_done(cal_done), .zc_evt(zc_evt),
      .hw_mute(hw_mute), .cal_req(cal_req), .gains_clear(gains_clear), .out_disc(out_disc));

   always @(negedge clk) if (gains_clear === 1'b1) gc_cnt++;

   function automatic logic [NCH-1:0] exp_muting(input logic [NCH-1:0] seen);
      return seen;
   endfunction

   function automatic logic [NCH-1:0] exp_release(input logic [NCH-1:0] seen);
      return ~seen;
   endfunction

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic ticks(input int n);
      repeat (n) begin ms_tick = 1'b1; step(1); ms_tick = 1'b0; step(1); end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic zc_walk(input bit muting, input string req);
      logic [NCH-1:0] seen = '0;
      for (int it = 0; it < 64 && seen != {NCH{1'b1}}; it++) begin
         logic [NCH-1:0] m = NCH'($urandom_range(0, (1 << NCH) - 1));
         zc_evt = m; step(1); zc_evt = '0;
         seen |= m;
         chk(req, out_disc, muting ? exp_muting(seen) : exp_release(seen));
         if (seen != {NCH{1'b1}}) chk(req, hw_mute, 1);
         step(int'($urandom_range(0, 2)));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      rst_n = 1'b0; ms_tick = 1'b0; supply_ok = 1'b0; mute_n = 1'b1;
      cal_done = 1'b0; zc_evt = '0;
      step(3); rst_n = 1'b1; step(2);
      // R1 reset state
      chk("R1 hw_mute", hw_mute, 1);
      chk("R1 out_disc", out_disc, 4'hF);
      chk("R1 cal_req", cal_req, 0);
      supply_ok = 1'b1; step(4);
      ticks(RST - 1); step(3);
      chk("R1 hold", cal_req, 0);
      ticks(1); step(1);
      chk("R2 cal_req", cal_req, 1);
      // R3 watchdog on power-up calibration
      ticks(WD - 1); step(3);
      chk("R3 still calibrating", cal_req, 1);
      chk("R4 no strobe yet", gc_cnt, 0);
      ticks(1); step(3);
      chk("R3 watchdog", cal_req, 0);
      chk("R4 strobe", gc_cnt, 1);
      chk("R9 still muted", hw_mute, 1);
      // R9 reconnect by random zero crossings
      zc_walk(1'b0, "R9 reconnect");
      step(1);
      chk("R9 unmuted", hw_mute, 0);
      chk("R11 connected", out_disc, 0);
      // R5 short mute pulse ignored
      mute_n = 1'b0; step(3); ticks(DEB - 1); mute_n = 1'b1; step(4); ticks(2); step(2);
      chk("R5 glitch", hw_mute, 0);
      // R5 accepted mute
      mute_n = 1'b0; step(3); ticks(DEB - 1); step(2);
      chk("R5 before", hw_mute, 0);
      ticks(1);
      chk("R5 after", hw_mute, 1);
      chk("R6 none off yet", out_disc, 0);
      zc_walk(1'b1, "R6 per-channel");
      step(1);
      chk("R8 cal_req", cal_req, 1);
      step(3);
      chk("R8 waits for done", cal_req, 1);
      cal_done = 1'b1; step(1); cal_done = 1'b0; step(2);
      chk("R8 done", cal_req, 0);
      chk("R8 held off", out_disc, 4'hF);
      chk("R8 muted", hw_mute, 1);
      chk("R4 no strobe on mute cal", gc_cnt, 1);
      // R9 release by timeout
      mute_n = 1'b1; step(6);
      chk("R9 gated", out_disc, 4'hF);
      ticks(ZC - 1); step(2);
      chk("R9 before timeout", out_disc, 4'hF);
      ticks(1); step(3);
      chk("R9 timeout", out_disc, 0);
      chk("R9 run", hw_mute, 0);
      // R7 mute with partial crossings then timeout
      mute_n = 1'b0; step(3); ticks(DEB); step(1);
      chk("R7 muting", hw_mute, 1);
      zc_evt = 4'h5; step(1); zc_evt = '0;
      chk("R6 partial", out_disc, 4'h5);
      ticks(ZC - 1); step(2);
      chk("R7 before", out_disc, 4'h5);
      ticks(1); step(3);
      chk("R7 timeout", out_disc, 4'hF);
      chk("R8 mute cal", cal_req, 1);
      ticks(WD); step(3);
      chk("R8 watchdog", cal_req, 0);
      chk("R8 stays muted", hw_mute, 1);
      // back to run, then supply loss
      mute_n = 1'b1; step(6); ticks(ZC); step(4);
      chk("R9 run again", hw_mute, 0);
      supply_ok = 1'b0; step(4);
      chk("R10 hw_mute", hw_mute, 1);
      chk("R10 out_disc", out_disc, 4'hF);
      ticks(RST + 2); step(2);
      chk("R10 no count while low", cal_req, 0);
      supply_ok = 1'b1; step(4); ticks(RST); step(1);
      chk("R10 restart", cal_req, 1);
      cal_done = 1'b1; step(1); cal_done = 1'b0; step(3);
      chk("R10 cal end", cal_req, 0);
      chk("R4 second strobe", gc_cnt, 2);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule